// File: doc/BRIEF.md
# Two-Stage Programmable Baud Generator

This block derives the two timing strobes a UART needs from one master clock. A first counter divides the master clock by a 16-bit divisor and emits a one-cycle sample strobe, used as the receiver's oversampling enable. A second counter counts those sample strobes and emits a one-cycle bit strobe at the end of every group of (ratio + 1) of them. The bit strobe paces the transmitter. The resulting bit rate is master_clock / (divisor × (ratio + 1)). Because the ratio is programmable, the number of samples per bit is not fixed at 16.

Software computes the two values and loads them through two write strobes. Any load restarts both counters, so no partial period survives a change of rate. An enable input pauses the chain. A synchronous clear input restores the power-up values. Both outputs are combinational decodes of the counter state, qualified by the enable, so a strobe is seen in the same cycle its count is reached.

Top module: `uart_rate_gen`

## Requirements
- R1: With divisor D in 2..65535 (16-bit field) and the chain enabled, sample_tick_o is high for exactly one cycle on the D-th, 2D-th, 3D-th, ... enabled cycle counted from the last restart, and is never high on two consecutive cycles.
- R2: With divisor 0 or 1, neither sample_tick_o nor bit_tick_o is ever asserted.
- R3: bit_tick_o is high exactly on the sample strobe that completes each group of (B + 1) sample strobes since the last restart, where B is the ratio, giving a bit period of D × (B + 1) enabled cycles.
- R4: The ratio is an 8-bit field, and every value 0..255 is honoured, including the usual range 4..254. With ratio 0, every sample strobe is also a bit strobe.
- R5: After rst_ni is released, the divisor is 0x028B (651) and the ratio is 0x0F (15). The first sample strobe falls on enabled cycle 651 and the first bit strobe on enabled cycle 10416. While rst_ni is low, both outputs are low.
- R6: A write to either value, sampled at a clock edge, clears both counters at that edge, and the new value takes effect from the next cycle. The next strobes are then timed from that next cycle.
- R7: While en_i is low, neither output is asserted and both counters hold their counts.
- R8: srst_i, sampled at a clock edge, restores both reset values and clears both counters. It takes priority over any write in the same cycle.
- R9: bit_tick_o is never high unless sample_tick_o is high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| srst_i | input | 1 | Synchronous clear to reset values |
| en_i | input | 1 | Chain enable |
| cd_we_i | input | 1 | Divisor write strobe |
| cd_i | input | 16 | Divisor write data |
| bdiv_we_i | input | 1 | Ratio write strobe |
| bdiv_i | input | 8 | Ratio write data |
| sample_tick_o | output | 1 | One-cycle oversampling strobe |
| bit_tick_o | output | 1 | One-cycle bit-period strobe |

## Verification
Both strobes are combinational decodes of registered counts qualified by en_i. A strobe therefore belongs to the cycle in which the count reaches its terminal value, with no extra latency. Writes, srst_i and enabled cycles take effect at the next edge. The bench drives inputs just after each falling edge and samples both outputs one time unit later, while that cycle's enable is already applied. It compares them against a closed-form prediction from the count of enabled cycles since the last restart. It then advances that count, or resets it, after the rising edge according to the inputs of the cycle.

// File: rtl/rate_gen_pkg.sv
package rate_gen_pkg;
  localparam int unsigned CD_W      = 16;
  localparam int unsigned BDIV_W    = 8;
  localparam logic [CD_W-1:0]   CD_RST   = 16'h028B;
  localparam logic [BDIV_W-1:0] BDIV_RST = 8'h0F;
endpackage

// File: rtl/rate_cfg.sv
module rate_cfg #(
  parameter int unsigned CD_W     = 16,
  parameter int unsigned BDIV_W   = 8,
  parameter logic [CD_W-1:0]   CD_RST   = '0,
  parameter logic [BDIV_W-1:0] BDIV_RST = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              srst_i,
  input  logic              cd_we_i,
  input  logic [CD_W-1:0]   cd_i,
  input  logic              bdiv_we_i,
  input  logic [BDIV_W-1:0] bdiv_i,
  output logic [CD_W-1:0]   cd_o,
  output logic [BDIV_W-1:0] bdiv_o,
  output logic              restart_o
);
  logic [CD_W-1:0]   cd_q;
  logic [BDIV_W-1:0] bdiv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cd_q   <= CD_RST;
      bdiv_q <= BDIV_RST;
    end else if (srst_i) begin
      cd_q   <= CD_RST;
      bdiv_q <= BDIV_RST;
    end else begin
      if (cd_we_i)   cd_q   <= cd_i;
      if (bdiv_we_i) bdiv_q <= bdiv_i;
    end
  end

  // any reload restarts the whole chain at the same edge
  assign restart_o = srst_i | cd_we_i | bdiv_we_i;
  assign cd_o      = cd_q;
  assign bdiv_o    = bdiv_q;
endmodule

// File: rtl/sample_div.sv
module sample_div #(
  parameter int unsigned CD_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            restart_i,
  input  logic            en_i,
  input  logic [CD_W-1:0] cd_i,
  output logic            tick_o
);
  localparam logic [CD_W-1:0] ONE = CD_W'(1);

  logic [CD_W-1:0] cnt_q;
  logic            cd_ok;
  logic            last;

  assign cd_ok  = cd_i > ONE;
  assign last   = cnt_q == (cd_i - ONE);
  assign tick_o = en_i & cd_ok & last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (restart_i)      cnt_q <= '0;
    else if (en_i && cd_ok)  cnt_q <= last ? '0 : cnt_q + ONE;
  end
endmodule

// File: rtl/bit_div.sv
module bit_div #(
  parameter int unsigned BDIV_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic              step_i,
  input  logic [BDIV_W-1:0] bdiv_i,
  output logic              tick_o
);
  logic [BDIV_W-1:0] cnt_q;
  logic              last;

  assign last   = cnt_q == bdiv_i;
  assign tick_o = step_i & last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (step_i)    cnt_q <= last ? '0 : cnt_q + BDIV_W'(1);
  end
endmodule

// File: rtl/uart_rate_gen.sv
module uart_rate_gen
  import rate_gen_pkg::*;
#(
  parameter int unsigned CD_W   = rate_gen_pkg::CD_W,
  parameter int unsigned BDIV_W = rate_gen_pkg::BDIV_W,
  parameter logic [CD_W-1:0]   CD_INIT   = rate_gen_pkg::CD_RST,
  parameter logic [BDIV_W-1:0] BDIV_INIT = rate_gen_pkg::BDIV_RST
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              srst_i,
  input  logic              en_i,
  input  logic              cd_we_i,
  input  logic [CD_W-1:0]   cd_i,
  input  logic              bdiv_we_i,
  input  logic [BDIV_W-1:0] bdiv_i,
  output logic              sample_tick_o,
  output logic              bit_tick_o
);
  logic [CD_W-1:0]   cd_q;
  logic [BDIV_W-1:0] bdiv_q;
  logic              restart;
  logic              s_tick;

  rate_cfg #(
    .CD_W(CD_W), .BDIV_W(BDIV_W), .CD_RST(CD_INIT), .BDIV_RST(BDIV_INIT)
  ) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .srst_i    (srst_i),
    .cd_we_i   (cd_we_i),
    .cd_i      (cd_i),
    .bdiv_we_i (bdiv_we_i),
    .bdiv_i    (bdiv_i),
    .cd_o      (cd_q),
    .bdiv_o    (bdiv_q),
    .restart_o (restart)
  );

  sample_div #(.CD_W(CD_W)) u_sample (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .en_i      (en_i),
    .cd_i      (cd_q),
    .tick_o    (s_tick)
  );

  bit_div #(.BDIV_W(BDIV_W)) u_bit (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .step_i    (s_tick),
    .bdiv_i    (bdiv_q),
    .tick_o    (bit_tick_o)
  );

  assign sample_tick_o = s_tick;
endmodule

// File: rtl/uart_rate_gen_chk.sv
module uart_rate_gen_chk #(
  parameter int unsigned CD_W = 16
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            srst_i,
  input logic            en_i,
  input logic            cd_we_i,
  input logic            bdiv_we_i,
  input logic [CD_W-1:0] cd_q,
  input logic            sample_tick_o,
  input logic            bit_tick_o
);
  AST_BIT_NEEDS_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_tick_o |-> sample_tick_o); // R9

  AST_SAMPLE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_tick_o |=> !sample_tick_o); // R1

  AST_SMALL_CD_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cd_q < CD_W'(2)) |-> !sample_tick_o); // R2

  AST_RESTART_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cd_we_i || bdiv_we_i) |=> !sample_tick_o); // R6

  AST_IDLE_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (!sample_tick_o && !bit_tick_o)); // R7

  AST_SRST_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> !bit_tick_o); // R8
endmodule

bind uart_rate_gen uart_rate_gen_chk #(.CD_W(CD_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .srst_i        (srst_i),
  .en_i          (en_i),
  .cd_we_i       (cd_we_i),
  .bdiv_we_i     (bdiv_we_i),
  .cd_q          (cd_q),
  .sample_tick_o (sample_tick_o),
  .bit_tick_o    (bit_tick_o)
);

// File: tb/tb_uart_rate_gen.sv
module tb_uart_rate_gen;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        srst_i = 1'b0;
  logic        en_i = 1'b0;
  logic        cd_we_i = 1'b0;
  logic [15:0] cd_i = '0;
  logic        bdiv_we_i = 1'b0;
  logic [7:0]  bdiv_i = '0;
  logic        sample_tick_o;
  logic        bit_tick_o;

  int unsigned errors = 0;
  int unsigned checks = 0;
  int unsigned cycles = 0;
  bit          done = 1'b0;

  // bench model: values in effect and enabled cycles since restart
  longint unsigned m_cd = 651;
  longint unsigned m_bd = 15;
  longint unsigned n = 0;
  string           tag = "R5";

  uart_rate_gen dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .srst_i(srst_i), .en_i(en_i),
    .cd_we_i(cd_we_i), .cd_i(cd_i), .bdiv_we_i(bdiv_we_i), .bdiv_i(bdiv_i),
    .sample_tick_o(sample_tick_o), .bit_tick_o(bit_tick_o)
  );

  always #10 clk_i = ~clk_i;

  function automatic bit exp_sample(bit en);
    if (!en || m_cd < 2) return 1'b0;
    return ((n + 1) % m_cd) == 0;
  endfunction

  function automatic bit exp_bit(bit en);
    if (!exp_sample(en)) return 1'b0;
    return (((n + 1) / m_cd) % (m_bd + 1)) == 0;
  endfunction

  task automatic chk(string req, bit act, bit exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%0b exp=%0b n=%0d cd=%0d bdiv=%0d", req, what, act, exp, n, m_cd, m_bd);
    end
  endtask

  task automatic step(bit en, bit cw, logic [15:0] cv, bit bw, logic [7:0] bv, bit sr);
    @(negedge clk_i);
    en_i = en; cd_we_i = cw; cd_i = cv; bdiv_we_i = bw; bdiv_i = bv; srst_i = sr;
    #1;
    chk(tag, sample_tick_o, exp_sample(en), "sample_tick");
    chk((tag == "R1") ? "R3" : tag, bit_tick_o, exp_bit(en), "bit_tick");
    if (bit_tick_o && !sample_tick_o) chk("R9", 1'b1, 1'b0, "bit without sample");
    @(posedge clk_i);
    if (sr) begin
      m_cd = 651; m_bd = 15; n = 0;
    end else if (cw || bw) begin
      if (cw) m_cd = cv;
      if (bw) m_bd = bv;
      n = 0;
    end else if (en) n++;
  endtask

  task automatic run(int num, bit en);
    for (int i = 0; i < num; i++) step(en, 1'b0, '0, 1'b0, '0, 1'b0);
  endtask

  task automatic load(logic [15:0] cv, logic [7:0] bv);
    step(1'b1, 1'b1, cv, 1'b1, bv, 1'b0);
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 180000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog act=%0d exp<=180000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    // R5: outputs low during reset
    repeat (3) @(negedge clk_i);
    chk("R5", sample_tick_o, 1'b0, "reset sample_tick");
    chk("R5", bit_tick_o, 1'b0, "reset bit_tick");
    rst_ni = 1'b1;

    // R5: power-up rates, first bit at enabled cycle 10416
    tag = "R5";
    run(10500, 1'b1);

    // R1 / R3: random small rates with occasional mid-period reloads (R6)
    for (int s = 0; s < 15; s++) begin
      tag = "R1";
      load(16'(2 + $urandom % 14), 8'($urandom % 24));
      for (int i = 0; i < 1500; i++) begin
        if ($urandom % 400 == 0) begin
          tag = "R6";
          step(1'b1, 1'b1, 16'($urandom % 16), 1'b0, '0, 1'b0);
        end else if ($urandom % 500 == 0) begin
          tag = "R6";
          step(1'b1, 1'b0, '0, 1'b1, 8'($urandom % 24), 1'b0);
        end else begin
          tag = ($urandom % 10 == 0) ? "R7" : "R1";
          step(tag != "R7", 1'b0, '0, 1'b0, '0, 1'b0);
        end
      end
    end

    // R2: divisor 0 and 1 stay silent
    tag = "R2";
    load(16'd0, 8'd0); run(300, 1'b1);
    load(16'd1, 8'd0); run(300, 1'b1);

    // R4: ratio 0 and 254 and 255
    tag = "R4";
    load(16'd3, 8'd0);   run(200, 1'b1);
    load(16'd2, 8'd254); run(1100, 1'b1);
    load(16'd2, 8'd255); run(1100, 1'b1);

    // R7: long pause in mid-period keeps counts
    tag = "R7";
    load(16'd300, 8'd4);
    tag = "R1"; run(700, 1'b1);
    tag = "R7"; run(400, 1'b0);
    tag = "R3"; run(2500, 1'b1);

    // R6: reload exactly on a strobe cycle
    tag = "R6";
    load(16'd5, 8'd2);
    run(4, 1'b1);
    load(16'd5, 8'd2);
    run(40, 1'b1);

    // R8: sync clear mid-period, and winning over a write
    tag = "R8";
    load(16'd7, 8'd1);
    run(9, 1'b1);
    step(1'b1, 1'b1, 16'd3, 1'b1, 8'd0, 1'b1);
    run(11000, 1'b1);

    // R1: full 16-bit divisor
    tag = "R1";
    load(16'hFFFF, 8'd0);
    run(65600, 1'b1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule